// File: doc/BRIEF.md
# Byte-Parity Protected SRAM Wrapper

This block puts a synchronous, word-wide memory behind a wrapper that protects every stored word with one even-parity bit per byte lane. On a write, the wrapper computes the parity of each byte that is written. It stores that parity next to the byte, in the same word. On a read, it computes the parity of the returned bytes again and compares it with the stored bits. A difference raises a per-read error strobe and sets an error flag. The flag stays set until it is cleared.

The wrapper records the word address of the first failing read since the flag was last clear. A lock control can be set once and is cleared only by reset. While the lock is set, the error flag is passed to a break output, which downstream logic can use to force its outputs to a safe state. For diagnostics, a per-lane parity-invert input lets a write store deliberately wrong parity. This makes it possible to exercise the error path through the normal port. Byte-lane write enables update only the selected bytes and their parity.

Top module: `bytepar_sram`

## Requirements
- R1: Each word holds DW data bits plus DW/8 parity bits. Parity bit k is even parity, the XOR of data bits 8k+7 down to 8k. A word written with all lane enables set and no parity inversion reads back with the same data and with rd_perr low.
- R2: Only the byte lanes whose enable bit wr_be[k] is 1 are updated, together with their parity bits. All other lanes keep their previous data and parity.
- R3: A read presented on a clock edge (acc_en=1, acc_we=0) gives rd_valid=1, rd_data and rd_perr during the following cycle. After a write or an idle cycle, rd_valid is 0.
- R4: When par_flip[k] is 1 on a write that enables lane k, the stored parity of lane k is inverted. A later read of that word raises rd_perr while the returned data is still correct. A later normal write to that lane stores correct parity again.
- R5: The parity check runs only on valid reads. rd_perr is 0 whenever rd_valid is 0, and writes never raise rd_perr or err_flag.
- R6: err_flag goes high in the cycle after a cycle with rd_perr=1. It then stays high until err_clr is 1 on a clock edge with no new failure. A failure on the same edge as err_clr leaves the flag set.
- R7: err_addr takes the word address of a failing read only when err_flag is low at that edge. Later failures leave it unchanged until the flag has been cleared.
- R8: A 1 on lock_set on a clock edge sets lock_q. Only rst clears lock_q, and err_clr has no effect on it.
- R9: brk_out is 1 exactly when err_flag and lock_q are both 1.
- R10: After reset, rd_valid, rd_perr, err_flag, lock_q, brk_out and err_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Word address, AW = clog2(DEPTH) |
| wr_data | input | DW | Write data |
| wr_be | input | DW/8 | Byte-lane write enables |
| par_flip | input | DW/8 | Invert stored parity of written lanes (diagnostic) |
| err_clr | input | 1 | Clear the sticky error flag |
| lock_set | input | 1 | Set the break lock (cleared only by reset) |
| rd_data | output | DW | Read data, valid one cycle after the read |
| rd_valid | output | 1 | rd_data and rd_perr are valid |
| rd_perr | output | 1 | Parity mismatch on the current read result |
| err_flag | output | 1 | Sticky parity error flag |
| err_addr | output | AW | Word address of the first failing read |
| lock_q | output | 1 | Break lock state |
| brk_out | output | 1 | Break request: err_flag gated by lock_q |

## Verification
The bench builds the wrapper with DW=32 and DEPTH=16, so there are four byte lanes and sixteen words. With this configuration every address can be written in full and then hit with each of the fifteen possible lane-enable patterns. Each pattern is checked by a readback against a lane-merging model that the bench computes. The small depth also keeps the fault scenarios short. The bench corrupts two different lanes, reads a clean neighbour word, repairs a corrupted lane, and clears the flag on the same edge as a new failure. It also recaptures the error address, sets the lock and resets it.

// File: rtl/bytepar_pkg.sv
package bytepar_pkg;
  localparam int LANE_W = 8;

  function automatic int lanes_of(input int width);
    return width / LANE_W;
  endfunction
endpackage

// File: rtl/bp_parity_gen.sv
module bp_parity_gen
  import bytepar_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = lanes_of(DW)
) (
  input  logic [DW-1:0] data,
  output logic [NB-1:0] par
);
  // even parity per byte lane
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign par[k] = ^data[LANE_W*k +: LANE_W];
  end
endmodule

// File: rtl/bp_lane_store.sv
module bp_lane_store
  import bytepar_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int NB = lanes_of(DW),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW = LANE_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] be,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wpar,
  output logic [DW-1:0] rdata,
  output logic [NB-1:0] rpar,
  output logic          rvalid,
  output logic [AW-1:0] raddr
);
  // one narrow memory per lane: data byte plus its parity bit
  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [SW-1:0] ram [DEPTH];
    logic [SW-1:0] q;

    always_ff @(posedge clk) begin
      if (en && we && be[k])
        ram[addr] <= {wpar[k], wdata[LANE_W*k +: LANE_W]};
      if (en && !we)
        q <= ram[addr];
    end

    assign rdata[LANE_W*k +: LANE_W] = q[LANE_W-1:0];
    assign rpar[k]                   = q[LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      raddr  <= '0;
    end else begin
      rvalid <= en && !we;
      if (en && !we)
        raddr <= addr;
    end
  end
endmodule

// File: rtl/bp_err_track.sv
module bp_err_track #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_fail,
  input  logic [AW-1:0] fail_addr,
  input  logic          clr,
  input  logic          lock_set,
  output logic          err_flag,
  output logic [AW-1:0] err_addr,
  output logic          lock_q,
  output logic          brk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_addr <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (lock_set)
        lock_q <= 1'b1;
      if (chk_fail) begin
        err_flag <= 1'b1;
        if (!err_flag)
          err_addr <= fail_addr;
      end else if (clr) begin
        err_flag <= 1'b0;
      end
    end
  end

  assign brk = err_flag & lock_q;

  // R6: flag holds without a clear
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag && !clr |=> err_flag);
  // R6: clear without a new failure drops the flag
  a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
    clr && !chk_fail |=> !err_flag);
  // R7: captured address frozen while flag stays set
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    err_flag && !clr |=> $stable(err_addr));
  // R8: lock only leaves through reset
  a_r8_lock_hold: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
endmodule

// File: rtl/bytepar_sram.sv
module bytepar_sram
  import bytepar_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int NB = lanes_of(DW),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [NB-1:0] wr_be,
  input  logic [NB-1:0] par_flip,
  input  logic          err_clr,
  input  logic          lock_set,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_perr,
  output logic          err_flag,
  output logic [AW-1:0] err_addr,
  output logic          lock_q,
  output logic          brk_out
);
  logic [NB-1:0] wpar_gen;
  logic [NB-1:0] wpar_store;
  logic [NB-1:0] rpar_stored;
  logic [NB-1:0] rpar_calc;
  logic [AW-1:0] rd_addr_q;

  bp_parity_gen #(.DW(DW)) u_wgen (
    .data (wr_data),
    .par  (wpar_gen)
  );

  assign wpar_store = wpar_gen ^ par_flip;

  bp_lane_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .en     (acc_en),
    .we     (acc_we),
    .addr   (acc_addr),
    .be     (wr_be),
    .wdata  (wr_data),
    .wpar   (wpar_store),
    .rdata  (rd_data),
    .rpar   (rpar_stored),
    .rvalid (rd_valid),
    .raddr  (rd_addr_q)
  );

  bp_parity_gen #(.DW(DW)) u_rgen (
    .data (rd_data),
    .par  (rpar_calc)
  );

  assign rd_perr = rd_valid && (rpar_calc != rpar_stored);

  bp_err_track #(.AW(AW)) u_err (
    .clk       (clk),
    .rst       (rst),
    .chk_fail  (rd_perr),
    .fail_addr (rd_addr_q),
    .clr       (err_clr),
    .lock_set  (lock_set),
    .err_flag  (err_flag),
    .err_addr  (err_addr),
    .lock_q    (lock_q),
    .brk       (brk_out)
  );

  // R9: a failing read under lock reaches the break output next cycle
  a_r9_break_on_locked_error: assert property (@(posedge clk) disable iff (rst)
    rd_perr && lock_q |=> brk_out);
endmodule

// File: tb/sim_bytepar_sram.sv
module sim_bytepar_sram;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int NB = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_en = 1'b0;
  logic          acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_be = '0;
  logic [NB-1:0] par_flip = '0;
  logic          err_clr = 1'b0;
  logic          lock_set = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          rd_perr;
  logic          err_flag;
  logic [AW-1:0] err_addr;
  logic          lock_q;
  logic          brk_out;

  int vec = 0;
  int bad = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  logic [NB-1:0] bad_par [DEPTH];

  always #5 clk = ~clk;

  bytepar_sram #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .wr_data(wr_data), .wr_be(wr_be), .par_flip(par_flip), .err_clr(err_clr),
    .lock_set(lock_set), .rd_data(rd_data), .rd_valid(rd_valid), .rd_perr(rd_perr),
    .err_flag(err_flag), .err_addr(err_addr), .lock_q(lock_q), .brk_out(brk_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int be);
    return 32'h5A3C96E1 ^ (32'(a) * 32'h01030507) ^ (32'(be) << 11);
  endfunction

  // write, update the lane-merging model, confirm no read result appears (R3, R5)
  task automatic wr(input int a, input logic [DW-1:0] d, input logic [NB-1:0] be,
                    input logic [NB-1:0] flip);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = AW'(a);
    wr_data = d; wr_be = be; par_flip = flip;
    for (int k = 0; k < NB; k++) begin
      if (be[k]) begin
        exp_mem[a][8*k +: 8] = d[8*k +: 8];
        bad_par[a][k] = flip[k];
      end
    end
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; wr_be = '0; par_flip = '0;
    chk("R3 rd_valid low after write", 64'(rd_valid), 64'd0);
    chk("R5 rd_perr low after write", 64'(rd_perr), 64'd0);
  endtask

  // read; result sampled in the cycle after the request edge (R3, R1, R4)
  task automatic rd_chk(input int a);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = AW'(a);
    @(negedge clk);
    acc_en = 1'b0;
    chk("R3 rd_valid after read", 64'(rd_valid), 64'd1);
    chk("R1/R2 read data", 64'(rd_data), 64'(exp_mem[a]));
    chk("R4/R5 rd_perr", 64'(rd_perr), 64'(|bad_par[a]));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 rd_valid reset", 64'(rd_valid), 64'd0);
    chk("R10 rd_perr reset", 64'(rd_perr), 64'd0);
    chk("R10 err_flag reset", 64'(err_flag), 64'd0);
    chk("R10 lock_q reset", 64'(lock_q), 64'd0);
    chk("R10 brk_out reset", 64'(brk_out), 64'd0);
    chk("R10 err_addr reset", 64'(err_addr), 64'd0);

    // R1: full-word fill and readback
    for (int a = 0; a < DEPTH; a++) begin
      exp_mem[a] = '0;
      bad_par[a] = '0;
      wr(a, pat(a, 15), 4'hF, 4'h0);
    end
    for (int a = 0; a < DEPTH; a++) rd_chk(a);

    // R2: every partial lane-enable pattern on every word
    for (int a = 0; a < DEPTH; a++) begin
      for (int be = 1; be < 15; be++) begin
        wr(a, ~pat(a, be), NB'(be), 4'h0);
        rd_chk(a);
      end
    end
    chk("R5 no error after clean traffic", 64'(err_flag), 64'd0);

    // R4: corrupt lane 2 of word 5, neighbour word 3 stays clean
    wr(5, 32'h11223344, 4'b0100, 4'b0100);
    rd_chk(3);
    rd_chk(5);
    @(negedge clk);
    chk("R6 flag set after failing read", 64'(err_flag), 64'd1);
    chk("R7 first failing address", 64'(err_addr), 64'd5);
    chk("R9 no break while unlocked", 64'(brk_out), 64'd0);

    // R7: second failure keeps first address
    wr(9, 32'hCAFE00F1, 4'b0001, 4'b0001);
    rd_chk(9);
    @(negedge clk);
    chk("R7 address held on later failure", 64'(err_addr), 64'd5);
    chk("R6 flag still set", 64'(err_flag), 64'd1);

    // R4: normal write repairs the lane
    wr(9, 32'h000000A7, 4'b0001, 4'b0000);
    rd_chk(9);

    // R8/R9: lock routes the flag to break
    @(negedge clk); lock_set = 1'b1;
    @(negedge clk); lock_set = 1'b0;
    chk("R8 lock set", 64'(lock_q), 64'd1);
    chk("R9 break with lock and flag", 64'(brk_out), 64'd1);

    // R6: clear; R8: lock unaffected by clear
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R6 flag cleared", 64'(err_flag), 64'd0);
    chk("R9 break drops with flag", 64'(brk_out), 64'd0);
    chk("R8 lock survives clear", 64'(lock_q), 64'd1);

    // R6: clear on the same edge as a failure leaves the flag set
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = 4'd5;
    @(negedge clk);
    acc_en = 1'b0; err_clr = 1'b1;
    chk("R4 rd_perr on corrupt word", 64'(rd_perr), 64'd1);
    @(negedge clk);
    err_clr = 1'b0;
    chk("R6 failure wins over clear", 64'(err_flag), 64'd1);
    chk("R7 address captured again", 64'(err_addr), 64'd5);

    // R7: recapture after a clear at a new address
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    wr(12, 32'h80FFEE01, 4'b1000, 4'b1000);
    rd_chk(12);
    @(negedge clk);
    chk("R7 new first address after clear", 64'(err_addr), 64'd12);
    chk("R9 break with new error", 64'(brk_out), 64'd1);

    // R8/R10: reset clears lock and flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R8 lock cleared by reset", 64'(lock_q), 64'd0);
    chk("R10 flag cleared by reset", 64'(err_flag), 64'd0);
    chk("R10 brk cleared by reset", 64'(brk_out), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vec++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule